// File: doc/BRIEF.md
# HDLC Bit-Stuffing Frame Transmitter

This block turns a stream of bytes into one serial HDLC line. Software-independent upstream logic offers bytes through a valid/ready handshake and marks the final byte of each frame. The block puts each frame on the line as a 0x7E flag, then the accepted bytes in order, then a 16-bit check sequence, then another flag. Between frames it sends flags back to back. The line advances by one bit only on a clock-enable strobe, so the block can run from a fast core clock at any lower bit rate.

The line is kept free of false flags. A counter of consecutive ones runs across the whole protected part of the frame, which is the bytes and the check sequence. It ignores byte edges. After five ones in a row it inserts a zero. Flag bits skip this logic and clear the counter. Inserted zeros are kept out of the check-sequence calculation. One holding register sits between the handshake and the shift register, so the next byte can arrive while the current one is being shifted out. If that register is still empty when a byte finishes, the frame is closed at that point.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While reset is held and until the first strobe after it, `line_out` is 1 and `in_ready` is 1. The first eight strobes after reset put a flag on the line as the bit sequence 0,1,1,1,1,1,1,0, which is 0x7E sent low bit first.
- R2: When no frame is pending, complete 8-bit flags follow each other with no gap. The line never carries seven ones in a row.
- R3: A byte is accepted on a clock edge where `in_valid` and `in_ready` are both 1. The bytes of a frame appear on the line in the order they were accepted, each sent least-significant bit first, between the opening flag and the check sequence.
- R4: Inside the bytes and the check sequence, every run of five ones is followed by an inserted 0. The run is counted across byte edges and is cleared by any 0 and by every flag bit.
- R5: The check sequence uses x^16+x^12+x^5+1 in bit-reversed form (0x8408). Its register is preset to 0xFFFF and is fed only the data bits, never the inserted zeros. It is sent inverted and low bit first. Running the same register over a frame's destuffed bytes and check sequence therefore leaves 0xF0B8.
- R6: If the first byte of the next frame is already held when the closing flag ends, that closing flag also serves as the next opening flag. Exactly one flag then separates the two frames.
- R7: `in_ready` is 0 while the holding register is full and while an inserted zero is waiting to go out.
- R8: If a byte without the last marker finishes while the holding register is empty, the block sends the check sequence and a closing flag at once. The frame then holds only the bytes accepted so far.
- R9: After the byte marked by `in_last` has been sent, the check sequence follows, then the closing flag.
- R10: On a clock edge where `bit_en` is 0, `line_out` does not change and the line sequence does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Line bit strobe; one line bit per high cycle |
| in_data | input | 8 | Byte offered for transmission |
| in_valid | input | 1 | `in_data` is valid |
| in_last | input | 1 | Offered byte is the final byte of its frame |
| in_ready | output | 1 | Block can accept a byte this cycle |
| line_out | output | 1 | Serial line bit |

## Verification
Zero insertion and the byte sequencing can fall on the same strobe. This happens when the fifth one is the last bit of a byte: a stuffed zero must come out just as the next byte is loaded, or just as the check sequence or the closing flag begins. The bench provokes this with bytes such as 0xF8 (ones at the top end), runs of 0xFF, 0x7E as data, and check sequences that happen to end in ones. It judges the result with an independent receiver model. That model finds flags, removes stuffed zeros, checks the 0xF0B8 residue and compares the bytes. It also confirms that `in_ready` stayed low until each inserted zero had gone out.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    localparam int BYTE_W  = 8;
    localparam int FLAG_W  = 8;
    localparam int FCS_W   = 16;
    localparam int RUN_LEN = 5;
    localparam int POS_W   = $clog2(FCS_W);
    localparam int FI_W    = $clog2(FLAG_W);

    localparam logic [FLAG_W-1:0] FLAG_PAT   = 8'h7E;
    localparam logic [FCS_W-1:0]  FCS_POLY   = 16'h8408;
    localparam logic [FCS_W-1:0]  FCS_PRESET = 16'hFFFF;

    typedef enum logic [1:0] {
        PH_FLAG,
        PH_DATA,
        PH_FCS
    } phase_e;

    typedef struct packed {
        logic              last;
        logic [BYTE_W-1:0] data;
    } tx_byte_t;

    // one bit of the reflected CRC, low bit of the register is the output end
    function automatic logic [FCS_W-1:0] crc_step(input logic [FCS_W-1:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        return (c >> 1) ^ (fb ? FCS_POLY : '0);
    endfunction

endpackage

// File: rtl/hdlc_fcs_gen.sv
module hdlc_fcs_gen
    import hdlc_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic             step,
    input  logic             bit_in,
    output logic [FCS_W-1:0] crc_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= FCS_PRESET;
        end else if (init) begin
            crc_q <= FCS_PRESET;
        end else if (step) begin
            crc_q <= crc_step(crc_q, bit_in);
        end
    end

endmodule

// File: rtl/hdlc_zero_inserter.sv
module hdlc_zero_inserter
    import hdlc_tx_pkg::*;
#(
    parameter int RUN = RUN_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic req_bit,
    input  logic req_protected,
    output logic stall,
    output logic line_out
);

    localparam int CW = $clog2(RUN + 1);

    logic [CW-1:0] run_cnt;
    logic          pend;
    logic          line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            pend    <= 1'b0;
            line_q  <= 1'b1;
        end else if (bit_en) begin
            if (pend) begin
                line_q  <= 1'b0;
                pend    <= 1'b0;
                run_cnt <= '0;
            end else begin
                line_q <= req_bit;
                if (!req_protected || !req_bit) begin
                    run_cnt <= '0;
                end else begin
                    run_cnt <= run_cnt + CW'(1);
                    pend    <= (run_cnt == CW'(RUN - 1));
                end
            end
        end
    end

    assign stall    = pend;
    assign line_out = line_q;

    assert_stuff_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (pend && bit_en) |=> (line_out == 1'b0));

    assert_run_bound_R2: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= CW'(RUN));

    assert_hold_line_R10: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(line_out));

endmodule

// File: rtl/hdlc_tx_seq.sv
module hdlc_tx_seq
    import hdlc_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              stall,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    input  logic [FCS_W-1:0]  crc_q,
    output logic              crc_init,
    output logic              crc_step_en,
    output logic              crc_bit,
    output logic              req_bit,
    output logic              req_protected
);

    localparam logic [POS_W-1:0] FLAG_END = POS_W'(FLAG_W - 1);
    localparam logic [POS_W-1:0] BYTE_END = POS_W'(BYTE_W - 1);
    localparam logic [POS_W-1:0] FCS_END  = POS_W'(FCS_W - 1);

    phase_e           phase;
    logic [POS_W-1:0] pos;
    logic [FCS_W-1:0] shreg;
    logic             cur_last;
    tx_byte_t         hold;
    logic             hold_full;

    logic             advance;
    logic             accept;
    logic             pos_end;
    logic             take_hold;
    logic [FCS_W-1:0] crc_next;
    logic             in_fcs;

    assign advance  = bit_en && !stall;
    assign in_ready = !hold_full && !stall;
    assign accept   = in_valid && in_ready;
    assign crc_next = crc_step(crc_q, shreg[0]);
    assign in_fcs   = (phase == PH_FCS);

    always_comb begin
        case (phase)
            PH_FLAG: pos_end = (pos == FLAG_END);
            PH_DATA: pos_end = (pos == BYTE_END);
            default: pos_end = (pos == FCS_END);
        endcase
    end

    assign take_hold = advance && pos_end && hold_full &&
                       ((phase == PH_FLAG) || (phase == PH_DATA && !cur_last));

    assign req_bit       = (phase == PH_FLAG) ? FLAG_PAT[pos[FI_W-1:0]] : shreg[0];
    assign req_protected = (phase != PH_FLAG);
    assign crc_init      = advance && (phase == PH_FLAG) && pos_end && hold_full;
    assign crc_step_en   = advance && (phase == PH_DATA);
    assign crc_bit       = shreg[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_FLAG;
            pos       <= '0;
            shreg     <= '0;
            cur_last  <= 1'b0;
            hold      <= '0;
            hold_full <= 1'b0;
        end else begin
            if (accept) begin
                hold      <= '{last: in_last, data: in_data};
                hold_full <= 1'b1;
            end else if (take_hold) begin
                hold_full <= 1'b0;
            end

            if (advance) begin
                pos   <= pos_end ? '0 : pos + POS_W'(1);
                shreg <= shreg >> 1;
                if (take_hold) begin
                    shreg    <= {{(FCS_W-BYTE_W){1'b0}}, hold.data};
                    cur_last <= hold.last;
                    phase    <= PH_DATA;
                end else if (pos_end) begin
                    case (phase)
                        PH_DATA: begin
                            phase <= PH_FCS;
                            shreg <= ~crc_next;
                        end
                        PH_FCS:  phase <= PH_FLAG;
                        default: phase <= PH_FLAG;
                    endcase
                end
            end
        end
    end

    assert_stall_freeze_R4: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(pos) && $stable(phase)));

    assert_fcs_entry_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(in_fcs) |-> ($past(cur_last) || !$past(hold_full)));

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
    import hdlc_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic              line_out
);

    logic             stall;
    logic             crc_init;
    logic             crc_step_en;
    logic             crc_bit;
    logic             req_bit;
    logic             req_protected;
    logic [FCS_W-1:0] crc_q;

    hdlc_tx_seq seq_i (
        .clk           (clk),
        .rst           (rst),
        .bit_en        (bit_en),
        .stall         (stall),
        .in_data       (in_data),
        .in_valid      (in_valid),
        .in_last       (in_last),
        .in_ready      (in_ready),
        .crc_q         (crc_q),
        .crc_init      (crc_init),
        .crc_step_en   (crc_step_en),
        .crc_bit       (crc_bit),
        .req_bit       (req_bit),
        .req_protected (req_protected)
    );

    hdlc_fcs_gen fcs_i (
        .clk    (clk),
        .rst    (rst),
        .init   (crc_init),
        .step   (crc_step_en),
        .bit_in (crc_bit),
        .crc_q  (crc_q)
    );

    hdlc_zero_inserter #(.RUN(RUN_LEN)) stuff_i (
        .clk           (clk),
        .rst           (rst),
        .bit_en        (bit_en),
        .req_bit       (req_bit),
        .req_protected (req_protected),
        .stall         (stall),
        .line_out      (line_out)
    );

    assert_ready_stuff_R7: assert property (@(posedge clk) disable iff (rst)
        (stall && !bit_en) |=> !in_ready);

endmodule

// File: tb/hdlc_tx_framer_tb_top.sv
`timescale 1ns/1ps
module hdlc_tx_framer_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       bit_en;
    logic [7:0] in_data;
    logic       in_valid;
    logic       in_last;
    logic       in_ready;
    logic       line_out;

    always #2 clk = ~clk;

    hdlc_tx_framer dut_i (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .in_data  (in_data),
        .in_valid (in_valid),
        .in_last  (in_last),
        .in_ready (in_ready),
        .line_out (line_out)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int en_div    = 1;
    bit strobe_on = 0;

    // scoreboard queues filled by the driver
    int         exp_len[$];
    logic [7:0] exp_byte[$];
    bit         exp_b2b[$];
    string      exp_tag[$];

    logic [7:0] pay[0:31];

    // receiver model state
    bit         rx_buf[$];
    bit         rx_sync = 0;
    int         run = 0;
    int         nsamp = 0;
    logic [7:0] first8 = 8'h00;
    bit         pend5 = 0;
    bit         rdy_hi = 0;
    int         nstuff = 0;
    int         flags_since = 0;
    int         flags_total = 0;
    bit         en_prev = 0;
    logic       last_line = 1'b1;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_step(input logic [15:0] c, input bit b);
        logic fb;
        fb = c[0] ^ b;
        return (c >> 1) ^ (fb ? 16'h8408 : 16'h0000);
    endfunction

    task automatic end_frame();
        int         nb;
        int         n;
        bit         b2b;
        string      tag;
        logic [15:0] c;
        logic [7:0] v;
        logic [7:0] e;
        nb = rx_buf.size();
        c  = 16'hFFFF;
        foreach (rx_buf[i]) c = ref_step(c, rx_buf[i]);
        check((nb % 8 == 0) && (nb >= 24), "R3", "frame bit count", nb, 24);
        check(c == 16'hF0B8, "R5", "check sequence residue", c, 16'hF0B8);
        if (exp_len.size() == 0) begin
            check(0, "R3", "frame with no expected entry", nb, 0);
            return;
        end
        n   = exp_len.pop_front();
        b2b = exp_b2b.pop_front();
        tag = exp_tag.pop_front();
        check(nb / 8 - 2 == n, tag, "payload length", nb / 8 - 2, n);
        for (int i = 0; i < n; i++) begin
            e = exp_byte.pop_front();
            if (8 * i + 7 < nb - 16) begin
                for (int k = 0; k < 8; k++) v[k] = rx_buf[8 * i + k];
                check(v == e, "R3", "payload byte", v, e);
            end
        end
        if (b2b) check(flags_since == 1, "R6", "flags between frames", flags_since, 1);
    endtask

    task automatic flag_found();
        flags_since++;
        flags_total++;
        if (rx_sync && rx_buf.size() >= 7) begin
            repeat (7) void'(rx_buf.pop_back());
        end else begin
            rx_buf.delete();
        end
        if (rx_buf.size() > 0) begin
            end_frame();
            flags_since = 0;
        end
        rx_buf.delete();
        rx_sync = 1;
    endtask

    task automatic process_bit(input bit b);
        nsamp++;
        if (nsamp <= 8) first8[nsamp-1] = b;
        if (nsamp == 8) check(first8 == 8'h7E, "R1", "first flag after reset", first8, 8'h7E);
        if (b) begin
            run++;
            if (run == 7) check(0, "R2", "seven ones on line", run, 6);
            if (run == 5) begin
                pend5  = 1;
                rdy_hi = 0;
            end else begin
                pend5 = 0;
            end
            if (rx_sync) rx_buf.push_back(b);
        end else begin
            if (run == 5) begin
                nstuff++;
                check(!rdy_hi, "R7", "in_ready low before inserted zero", rdy_hi, 0);
            end else if (run == 6) begin
                flag_found();
            end else if (rx_sync) begin
                rx_buf.push_back(b);
            end
            run   = 0;
            pend5 = 0;
        end
    endtask

    // monitor: samples away from the active edge
    always @(negedge clk) begin
        if (!rst && strobe_on) begin
            if (en_prev) process_bit(line_out);
            else check(line_out === last_line, "R10", "line held without strobe", line_out, last_line);
            if (pend5 && in_ready) rdy_hi = 1;
            en_prev   = bit_en;
            last_line = line_out;
        end
    end

    // strobe generator
    initial begin
        int k;
        k = 0;
        bit_en = 1'b0;
        wait (strobe_on);
        forever begin
            @(posedge clk);
            #1;
            k++;
            bit_en = (k % en_div == 0);
        end
    end

    task automatic send_frame(input int n, input bit use_last, input bit b2b, input string tag);
        exp_len.push_back(n);
        exp_b2b.push_back(b2b);
        exp_tag.push_back(tag);
        for (int i = 0; i < n; i++) exp_byte.push_back(pay[i]);
        for (int i = 0; i < n; i++) begin
            in_data  = pay[i];
            in_last  = use_last && (i == n - 1);
            in_valid = 1'b1;
            do @(negedge clk); while (!in_ready);
            @(posedge clk);
            #1;
            in_valid = 1'b0;
            in_last  = 1'b0;
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            check(0, "R3", "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int snap;
        rst      = 1'b1;
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_data  = 8'h00;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(line_out == 1'b1, "R1", "line during reset", line_out, 1);
        check(in_ready == 1'b1, "R1", "ready during reset", in_ready, 1);
        @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(line_out == 1'b1, "R1", "line before first strobe", line_out, 1);
        check(in_ready == 1'b1, "R1", "ready before first strobe", in_ready, 1);
        strobe_on = 1;
        wait_cycles(40);

        // R9: ordinary frame closed by the last marker
        pay[0] = 8'hA5; pay[1] = 8'h03; pay[2] = 8'h12;
        pay[3] = 8'h34; pay[4] = 8'h56; pay[5] = 8'h9C;
        send_frame(6, 1, 0, "R9");
        wait_cycles(200);

        // R4: long runs of ones across byte edges
        for (int i = 0; i < 5; i++) pay[i] = 8'hFF;
        send_frame(5, 1, 0, "R4");
        // R6: next frame already waiting, ones at the top end of bytes
        pay[0] = 8'hF8; pay[1] = 8'h1F; pay[2] = 8'h7E;
        pay[3] = 8'h3E; pay[4] = 8'hFC; pay[5] = 8'hB8;
        send_frame(6, 1, 1, "R6");
        wait_cycles(300);

        // R8: no last marker, holding register runs dry
        pay[0] = 8'h11; pay[1] = 8'h22; pay[2] = 8'h33;
        send_frame(3, 0, 0, "R8");
        wait_cycles(300);

        // slower strobe: R10 between strobes
        en_div = 3;
        wait_cycles(30);
        pay[0] = 8'hC3;
        send_frame(1, 1, 0, "R9");
        wait_cycles(400);
        for (int i = 0; i < 20; i++) pay[i] = 8'(i * 37 + 8'hF1);
        send_frame(20, 1, 0, "R3");
        pay[0] = 8'hFF; pay[1] = 8'hFF;
        send_frame(2, 1, 1, "R6");
        wait_cycles(900);

        // R2: idle flags back to back
        snap = flags_total;
        wait_cycles(3 * 8 * 6);
        check(flags_total - snap >= 5, "R2", "idle flags", flags_total - snap, 5);
        check(exp_len.size() == 0, "R3", "frames still outstanding", exp_len.size(), 0);
        check(nstuff >= 10, "R4", "inserted zeros seen", nstuff, 10);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule